// File: doc/BRIEF.md
# Two-Pass Separable Sub-Pixel Interpolator

This block builds one 8x8 motion-compensated prediction block when both the horizontal and the vertical fractional offsets are non-zero. A host pulses `start` with the two offset modes, the rounding flag and the put/average choice. It then streams an 11x11 window of reference pixels in raster order, one per accepted `src_valid`. The window covers rows and columns -1 through +9 relative to the block origin. The block emits the 64 result pixels in raster order on `out_valid`/`out_pix`.

The first pass runs down each column. As each reference row arrives, a three-row history supplies the four vertical taps, and one signed intermediate is written per column into an 8-row by 11-column scratch store. The right shift of this pass depends on the pair of modes, and its rounding constant folds in the rounding flag, so the precision is shared between the passes. The second pass reads four neighbouring intermediates of a completed row, applies the horizontal taps and a fixed normalisation, and clamps to the pixel range.

In average mode the block fetches the existing destination pixel through a simple read port. `dst_rd` and `dst_addr` are driven in a cycle, and `dst_pix` must hold the addressed pixel in that same cycle. The fetched pixel is then blended with the filtered result.

Top module: `subpel_interp`

## Requirements
- R1: After reset, `out_valid` and `dst_rd` are low. Source pixels presented before the first `start` are discarded and produce no output.
- R2: The first pass gives each mode a weight: mode 1 (quarter) weighs 5, mode 2 (half) weighs 1 and mode 3 (three-quarter) weighs 5. The shift is s = (weight(hmode) + weight(vmode)) >> 1. Each intermediate is (vertical sum + 2^(s-1) + rnd - 1) shifted arithmetically right by s, which rounds toward minus infinity.
- R3: Taps act on four consecutive window positions (one before, current, one after, two after). Mode 1 uses -4, 53, 18, -3. Mode 2 uses -1, 9, 9, -1. Mode 3 uses -3, 18, 53, -4. `vmode` selects the taps over window rows and `hmode` the taps over intermediate columns. Output (y, x) uses window rows y..y+3 and columns x..x+3.
- R4: The second pass computes (horizontal sum + 64 - rnd) shifted arithmetically right by 7.
- R5: The second-pass result is saturated to 0..255 before any averaging.
- R6: With `avg_en` set, the output is (p + d + 1) >> 1, where p is the saturated result and d is `dst_pix` read at `dst_addr` = row*8 + col.
- R7: Intermediates remain signed and unclamped. Negative values from the first pass reach the second pass unchanged.
- R8: Each `start` yields exactly 64 outputs in raster order. `dst_rd` is high in the cycle just before each `out_valid`, with `dst_addr` equal to that pixel's raster index.
- R9: Output row y is not begun until (y+4)*11 source pixels of the current block have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a block and latches the configuration |
| hmode | input | 2 | Horizontal offset mode, 1..3 |
| vmode | input | 2 | Vertical offset mode, 1..3 |
| rnd_sel | input | 1 | Rounding flag |
| avg_en | input | 1 | 1: average with destination, 0: put |
| src_valid | input | 1 | Reference pixel present on `src_pix` |
| src_pix | input | 8 | Reference pixel, window raster order |
| dst_rd | output | 1 | Destination fetch strobe |
| dst_addr | output | 6 | Raster index of the destination pixel |
| dst_pix | input | 8 | Destination pixel at `dst_addr`, same cycle |
| out_valid | output | 1 | Result pixel valid |
| out_pix | output | 8 | Result pixel |

## Verification
The bench sweeps every mode pair, both rounding values and both put and average, across four image patterns, with random gaps in the source stream. Column stripes push the second pass below zero and above 255. A design missing the clamp would wrap those pixels, for example to 228 instead of 0. Row stripes make the first pass negative, and a design that clamped or zero-extended the intermediates would produce bright artefacts there. A wrong mode-pair shift or a dropped `rnd - 1` term in the first rounder shows up as an off-by-one on the ramp and random patterns. Reading a scratch row before it is complete breaks the row-readiness check, and an off-by-one destination fetch corrupts the averaged outputs.

// File: rtl/subpel_pkg.sv
package subpel_pkg;

    typedef enum logic [1:0] {
        SP_NONE    = 2'd0,
        SP_QUARTER = 2'd1,
        SP_HALF    = 2'd2,
        SP_THREEQ  = 2'd3
    } sp_mode_e;

    typedef struct packed {
        sp_mode_e hmode;
        sp_mode_e vmode;
        logic     rnd;
        logic     avg;
    } sp_cfg_t;

    localparam int NTAPS   = 4;
    localparam int H_SHIFT = 7;
    localparam int H_BIAS  = 64;

    // Coefficient of tap k (0 = one before the centre) for a mode.
    function automatic int tap_coef(input sp_mode_e m, input int k);
        int c;
        c = 0;
        case (m)
            SP_QUARTER: case (k)
                0: c = -4;
                1: c = 53;
                2: c = 18;
                default: c = -3;
            endcase
            SP_HALF: case (k)
                0: c = -1;
                1: c = 9;
                2: c = 9;
                default: c = -1;
            endcase
            SP_THREEQ: case (k)
                0: c = -3;
                1: c = 18;
                2: c = 53;
                default: c = -4;
            endcase
            default: c = 0;
        endcase
        return c;
    endfunction

    function automatic int mode_weight(input sp_mode_e m);
        int w;
        case (m)
            SP_HALF:               w = 1;
            SP_QUARTER, SP_THREEQ: w = 5;
            default:               w = 0;
        endcase
        return w;
    endfunction

    function automatic int mid_shift(input sp_cfg_t c);
        return (mode_weight(c.hmode) + mode_weight(c.vmode)) >> 1;
    endfunction

    function automatic int mid_round(input sp_cfg_t c);
        int s;
        s = mid_shift(c);
        if (s == 0) return 0;
        return (1 << (s - 1)) + int'(c.rnd) - 1;
    endfunction

endpackage

// File: rtl/subpel_vpass.sv
module subpel_vpass
    import subpel_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int COLS  = 11,
    parameter int MID_W = 16
) (
    input  logic                    clk,
    input  logic                    shift_en,
    input  logic [PIX_W-1:0]        pix_in,
    input  sp_mode_e                vmode,
    input  int                      shamt,
    input  int                      bias,
    output logic signed [MID_W-1:0] mid_out
);
    localparam int HIST = (NTAPS - 1) * COLS;

    logic [PIX_W-1:0] hist [HIST];
    logic [PIX_W-1:0] win  [NTAPS];

    // Three reference rows of history; one row back is COLS entries deep.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            hist[0] <= pix_in;
            for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        end
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_win
        if (k == NTAPS - 1) begin : g_cur
            assign win[k] = pix_in;
        end else begin : g_old
            assign win[k] = hist[(NTAPS - 1 - k) * COLS - 1];
        end
    end

    int vsum;
    int vscaled;

    always_comb begin
        vsum = 0;
        for (int k = 0; k < NTAPS; k++) vsum += tap_coef(vmode, k) * int'(win[k]);
        vscaled = (vsum + bias) >>> shamt;
        mid_out = vscaled[MID_W-1:0];
    end

endmodule

// File: rtl/subpel_midbuf.sv
module subpel_midbuf #(
    parameter int MID_W = 16,
    parameter int DEPTH = 88,
    parameter int NRD   = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic signed [MID_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic signed [MID_W-1:0] rdata [NRD]
);
    logic signed [MID_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rdata[k] = mem[raddr + AW'(k)];
    end

endmodule

// File: rtl/subpel_hpass.sv
module subpel_hpass
    import subpel_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MID_W = 16,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  sp_mode_e                hmode,
    input  logic                    rnd,
    input  logic                    avg,
    input  logic signed [MID_W-1:0] taps_in [NTAPS],
    input  logic [PIX_W-1:0]        dst_pix,
    output logic                    out_valid,
    output logic [PIX_W-1:0]        out_pix
);
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    int                      hsum;
    logic signed [ACC_W-1:0] hacc;
    logic signed [ACC_W-1:0] hnorm;
    logic [PIX_W-1:0]        put_pix;
    logic [PIX_W:0]          blend;
    logic [PIX_W-1:0]        fin_pix;

    always_comb begin
        hsum = 0;
        for (int k = 0; k < NTAPS; k++) hsum += tap_coef(hmode, k) * int'(taps_in[k]);
        hacc  = ACC_W'(hsum + H_BIAS - int'(rnd));
        hnorm = hacc >>> H_SHIFT;
        if (hnorm < 0)                        put_pix = '0;
        else if (hnorm > ACC_W'(PIX_MAX))     put_pix = PIX_W'(PIX_MAX);
        else                                  put_pix = hnorm[PIX_W-1:0];
        blend   = {1'b0, put_pix} + {1'b0, dst_pix} + (PIX_W+1)'(1);
        fin_pix = avg ? blend[PIX_W:1] : put_pix;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= go;
            if (go) out_pix <= fin_pix;
        end
    end

endmodule

// File: rtl/subpel_interp.sv
module subpel_interp
    import subpel_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int BLK    = 8,
    parameter int MID_W  = 16,
    parameter int ACC_W  = 24,
    parameter int ADDR_W = $clog2(BLK * BLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        hmode,
    input  logic [1:0]        vmode,
    input  logic              rnd_sel,
    input  logic              avg_en,
    input  logic              src_valid,
    input  logic [PIX_W-1:0]  src_pix,
    output logic              dst_rd,
    output logic [ADDR_W-1:0] dst_addr,
    input  logic [PIX_W-1:0]  dst_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int COLS   = BLK + NTAPS - 1;
    localparam int ROWS   = COLS;
    localparam int DEPTH  = BLK * COLS;
    localparam int BUF_AW = $clog2(DEPTH);
    localparam int CW     = $clog2(COLS + 1);

    sp_cfg_t                 cfg_q;
    logic [CW-1:0]           s_row, s_col, rows_done, h_row, h_col;
    logic                    take, mid_we, row_end, h_go;
    logic signed [MID_W-1:0] mid_val;
    logic signed [MID_W-1:0] taps [NTAPS];
    logic [BUF_AW-1:0]       waddr, raddr;

    assign take    = src_valid && !start && (s_row < CW'(ROWS));
    assign mid_we  = take && (s_row >= CW'(NTAPS - 1));
    assign row_end = (s_col == CW'(COLS - 1));
    assign waddr   = BUF_AW'((int'(s_row) - (NTAPS - 1)) * COLS + int'(s_col));

    // A scratch row is read only once all of its columns are written.
    assign h_go     = (h_row < rows_done);
    assign raddr    = BUF_AW'(int'(h_row) * COLS + int'(h_col));
    assign dst_rd   = h_go;
    assign dst_addr = ADDR_W'(int'(h_row) * BLK + int'(h_col));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            s_row     <= CW'(ROWS);
            s_col     <= '0;
            rows_done <= '0;
            h_row     <= '0;
            h_col     <= '0;
        end else if (start) begin
            cfg_q     <= '{hmode: sp_mode_e'(hmode), vmode: sp_mode_e'(vmode),
                           rnd: rnd_sel, avg: avg_en};
            s_row     <= '0;
            s_col     <= '0;
            rows_done <= '0;
            h_row     <= '0;
            h_col     <= '0;
        end else begin
            if (take) begin
                if (row_end) begin
                    s_col <= '0;
                    s_row <= s_row + CW'(1);
                    if (mid_we) rows_done <= s_row - CW'(NTAPS - 2);
                end else begin
                    s_col <= s_col + CW'(1);
                end
            end
            if (h_go) begin
                if (h_col == CW'(BLK - 1)) begin
                    h_col <= '0;
                    h_row <= h_row + CW'(1);
                end else begin
                    h_col <= h_col + CW'(1);
                end
            end
        end
    end

    subpel_vpass #(.PIX_W(PIX_W), .COLS(COLS), .MID_W(MID_W)) u_vpass (
        .clk      (clk),
        .shift_en (take),
        .pix_in   (src_pix),
        .vmode    (cfg_q.vmode),
        .shamt    (mid_shift(cfg_q)),
        .bias     (mid_round(cfg_q)),
        .mid_out  (mid_val)
    );

    subpel_midbuf #(.MID_W(MID_W), .DEPTH(DEPTH), .NRD(NTAPS), .AW(BUF_AW)) u_midbuf (
        .clk   (clk),
        .we    (mid_we),
        .waddr (waddr),
        .wdata (mid_val),
        .raddr (raddr),
        .rdata (taps)
    );

    subpel_hpass #(.PIX_W(PIX_W), .MID_W(MID_W), .ACC_W(ACC_W)) u_hpass (
        .clk       (clk),
        .rst       (rst),
        .go        (h_go),
        .hmode     (cfg_q.hmode),
        .rnd       (cfg_q.rnd),
        .avg       (cfg_q.avg),
        .taps_in   (taps),
        .dst_pix   (dst_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

endmodule

// File: rtl/subpel_interp_chk.sv
module subpel_interp_chk #(
    parameter int BLK    = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              src_valid,
    input logic              dst_rd,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              out_valid
);
    localparam int COLS  = BLK + 3;
    localparam int TOTAL = COLS * COLS;
    localparam int NPIX  = BLK * BLK;

    int                src_cnt;
    int                out_cnt;
    logic              armed;
    logic [ADDR_W-1:0] exp_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_cnt  <= 0;
            out_cnt  <= 0;
            armed    <= 1'b0;
            exp_addr <= '0;
        end else if (start) begin
            src_cnt  <= 0;
            out_cnt  <= 0;
            armed    <= 1'b1;
            exp_addr <= '0;
        end else begin
            if (armed && src_valid && src_cnt < TOTAL) src_cnt <= src_cnt + 1;
            if (out_valid) out_cnt <= out_cnt + 1;
            if (dst_rd) exp_addr <= exp_addr + ADDR_W'(1);
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !dst_rd));

    // R8
    fetch_then_emit_chk: assert property (@(posedge clk) disable iff (rst)
        dst_rd |=> out_valid);

    // R8
    emit_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(dst_rd));

    // R8
    raster_addr_chk: assert property (@(posedge clk) disable iff (rst)
        dst_rd |-> (dst_addr == exp_addr));

    // R8
    out_count_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cnt < NPIX));

    // R9
    row_ready_chk: assert property (@(posedge clk) disable iff (rst)
        dst_rd |-> (src_cnt >= (int'(dst_addr) / BLK + 4) * COLS));

endmodule

bind subpel_interp subpel_interp_chk #(.BLK(BLK), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .src_valid (src_valid),
    .dst_rd    (dst_rd),
    .dst_addr  (dst_addr),
    .out_valid (out_valid)
);

// File: tb/subpel_interp_bench.sv
module subpel_interp_bench;
    localparam int BLK  = 8;
    localparam int COLS = 11;
    localparam int NPIX = 64;

    logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0] hmode = 2'd1, vmode = 2'd1;
    logic       rnd_sel = 1'b0, avg_en = 1'b0, src_valid = 1'b0;
    logic [7:0] src_pix = 8'd0;
    logic       dst_rd, out_valid;
    logic [5:0] dst_addr;
    logic [7:0] dst_pix, out_pix;

    int    checks = 0, fails = 0, sent = 0, got = 0, idle_outs = 0;
    bit    expect_out = 1'b0;
    int    img [COLS][COLS];
    logic [7:0] dst_mem [NPIX];
    int    exp_pix [NPIX];
    string exp_tag [NPIX];

    always #2 clk = ~clk;

    assign dst_pix = dst_mem[dst_addr];

    subpel_interp u_subpel_interp (
        .clk(clk), .rst(rst), .start(start), .hmode(hmode), .vmode(vmode),
        .rnd_sel(rnd_sel), .avg_en(avg_en), .src_valid(src_valid), .src_pix(src_pix),
        .dst_rd(dst_rd), .dst_addr(dst_addr), .dst_pix(dst_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int coef(int m, int k);
        int t[4];
        case (m)
            1: t = '{-4, 53, 18, -3};
            2: t = '{-1, 9, 9, -1};
            default: t = '{-3, 18, 53, -4};
        endcase
        return t[k];
    endfunction

    function automatic int wt(int m);
        return (m == 2) ? 1 : 5;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary_and_end;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (!expect_out) begin
                    idle_outs++;
                end else if (got >= NPIX) begin
                    check(1'b0, "R8 extra output", got + 1, NPIX);
                end else begin
                    check(int'(out_pix) == exp_pix[got], exp_tag[got], int'(out_pix), exp_pix[got]);
                    check((sent - int'(src_valid)) >= (got / BLK + 4) * COLS, "R9 row readiness",
                          sent - int'(src_valid), (got / BLK + 4) * COLS);
                    got++;
                end
            end
            if (dst_rd && expect_out)
                check(int'(dst_addr) == got, "R8 dst_addr order", int'(dst_addr), got);
        end
    end

    task automatic compute_ref(int h, int v, int r, int a, string put_tag);
        int mid [BLK][COLS];
        int sh, rv, acc, raw, p;
        sh = (wt(h) + wt(v)) >> 1;
        rv = (1 << (sh - 1)) + r - 1;
        for (int y = 0; y < BLK; y++)
            for (int c = 0; c < COLS; c++) begin
                acc = 0;
                for (int k = 0; k < 4; k++) acc += coef(v, k) * img[y+k][c];
                mid[y][c] = (acc + rv) >>> sh;
            end
        for (int y = 0; y < BLK; y++)
            for (int x = 0; x < BLK; x++) begin
                acc = 0;
                for (int k = 0; k < 4; k++) acc += coef(h, k) * mid[y][x+k];
                raw = (acc + 64 - r) >>> 7;
                p = (raw < 0) ? 0 : ((raw > 255) ? 255 : raw);
                if (a != 0) begin
                    exp_pix[y*BLK+x] = (p + int'(dst_mem[y*BLK+x]) + 1) >> 1;
                    exp_tag[y*BLK+x] = "R6 average";
                end else begin
                    exp_pix[y*BLK+x] = p;
                    exp_tag[y*BLK+x] = (raw < 0 || raw > 255) ? "R5 saturation" : put_tag;
                end
            end
    endtask

    task automatic run_block(int h, int v, int r, int a, int pat);
        string tag;
        int t;
        for (int rr = 0; rr < COLS; rr++)
            for (int cc = 0; cc < COLS; cc++)
                case (pat)
                    0: img[rr][cc] = $urandom_range(0, 255);
                    1: img[rr][cc] = (rr * 23 + cc * 9) % 256;
                    2: img[rr][cc] = (cc % 4 == 0 || cc % 4 == 3) ? 255 : 0;
                    default: img[rr][cc] = (rr % 4 == 0 || rr % 4 == 3) ? 255 : 0;
                endcase
        for (int i = 0; i < NPIX; i++) dst_mem[i] = 8'($urandom_range(0, 255));
        case (pat)
            0: tag = "R3 taps";
            1: tag = (r != 0) ? "R4 second rounder" : "R2 first pass";
            2: tag = "R3 taps";
            default: tag = "R7 signed intermediate";
        endcase
        compute_ref(h, v, r, a, tag);
        got = 0;
        sent = 0;
        expect_out = 1'b1;
        @(posedge clk); #1;
        hmode = 2'(h); vmode = 2'(v); rnd_sel = 1'(r); avg_en = 1'(a); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int rr = 0; rr < COLS; rr++)
            for (int cc = 0; cc < COLS; cc++) begin
                while ($urandom_range(0, 3) == 0) begin
                    src_valid = 1'b0;
                    @(posedge clk); #1;
                end
                src_valid = 1'b1;
                src_pix = 8'(img[rr][cc]);
                sent++;
                @(posedge clk); #1;
            end
        src_valid = 1'b0;
        t = 0;
        while (got < NPIX && t < 300) begin
            @(posedge clk); #1;
            t++;
        end
        repeat (3) @(posedge clk);
        #1;
        check(got == NPIX, "R8 output count", got, NPIX);
        expect_out = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NPIX; i++) dst_mem[i] = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !dst_rd, "R1 reset outputs", int'(out_valid) + int'(dst_rd), 0);
        @(posedge clk); #1;
        for (int i = 0; i < 150; i++) begin
            src_valid = 1'b1;
            src_pix = 8'(i);
            @(posedge clk); #1;
        end
        src_valid = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        check(idle_outs == 0, "R1 pixels before start", idle_outs, 0);
        for (int pat = 0; pat < 4; pat++)
            for (int h = 1; h <= 3; h++)
                for (int v = 1; v <= 3; v++)
                    for (int r = 0; r < 2; r++)
                        for (int a = 0; a < 2; a++)
                            run_block(h, v, r, a, pat);
        check(idle_outs == 0, "R8 no stray outputs", idle_outs, 0);
        summary_and_end();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired: actual %0d outputs expected %0d", got, NPIX);
        summary_and_end();
    end

endmodule